// File: doc/BRIEF.md
# Two-Level Standby Controller

This block decides when a small processor may sleep and how it wakes. It has two sleep depths. Light sleep gates only the CPU clock, so peripherals keep running and an interrupt brings the CPU back on the next cycle. Deep sleep also stops the main oscillator, which stops every clock. Waking from deep sleep turns the oscillator on first. The CPU and peripheral clocks stay off until a stabilisation count, chosen by a 4-bit select, has run out.

Each sleep depth is entered by a one-cycle command strobe from the CPU. When deep sleep is entered, the block sends a one-cycle partial-reset pulse to a chosen group of peripheral registers. A low-supply flag overrides every state and raises a reset request. The outputs drive external clock-gate cells and the reset sequencer. The block also reports its state as a 2-bit code.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, state_o is 2'b00 (run), all three enables are 1, and part_rst_o and rst_req_o are 0.
- R2: In run with irq_i low, a light_req_i strobe moves the block to light sleep (state_o 2'b01). In light sleep cpu_clk_en_o is 0 while per_clk_en_o and osc_en_o stay 1.
- R3: In run with irq_i low, a deep_req_i strobe moves the block to deep sleep (state_o 2'b10). In deep sleep osc_en_o, per_clk_en_o and cpu_clk_en_o are all 0.
- R4: part_rst_o is 1 for exactly one cycle, the first cycle in deep sleep. Entering light sleep never raises it.
- R5: irq_i high in light sleep returns the block to run (state_o 2'b00, cpu_clk_en_o 1) one clock later, with no wait.
- R6: irq_i high in deep sleep moves the block to waking (state_o 2'b11). In waking osc_en_o is 1 and cpu_clk_en_o and per_clk_en_o are 0.
- R7: The block stays in waking for exactly 2^(stab_sel_i + BASE_EXP) cycles and then enters run. stab_sel_i is sampled on entry to deep sleep; later changes to it have no effect on the wait. irq_i activity during the wait neither shortens nor lengthens it.
- R8: A sleep strobe that arrives while irq_i is high is ignored, and the block stays in run.
- R9: When both strobes are high in the same cycle, deep sleep wins.
- R10: low_volt_i high in any state sets rst_req_o one clock later and forces run with every clock enabled. Sleep strobes are ignored while the flag is high. The block stays in run after the flag clears, and rst_req_o falls one clock after the flag does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| light_req_i | input | 1 | Light-sleep command strobe |
| deep_req_i | input | 1 | Deep-sleep command strobe |
| irq_i | input | 1 | Pending interrupt request |
| low_volt_i | input | 1 | Low-supply flag |
| stab_sel_i | input | SEL_W | Stabilisation length select |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| part_rst_o | output | 1 | Partial-reset pulse for selected peripheral registers |
| rst_req_o | output | 1 | Reset request to the reset sequencer |
| state_o | output | 2 | State code: 00 run, 01 light, 10 deep, 11 waking |

## Verification
Some behaviour is checked by assertions on every cycle:
- the enable pattern that belongs to each state code;
- that the partial-reset pulse only ever coincides with a fresh run-to-deep transition;
- the single-step exit from light sleep;
- interrupt blocking of sleep strobes;
- deep-over-light priority;
- the low-voltage override.

The exact length of the stabilisation wait needs directed scenarios. So do the sampling of the select at deep-sleep entry, the fact that interrupts during the wait have no effect, and the one-cycle width of the partial-reset pulse. Each of these is checked by counting cycles at the ports.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_LIGHT = 2'b01,
    ST_DEEP  = 2'b10,
    ST_WAKE  = 2'b11
  } sb_state_e;
endpackage

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      light_req_i,
  input  logic      deep_req_i,
  input  logic      irq_i,
  input  logic      low_volt_i,
  input  logic      tmr_done_i,
  output sb_state_e state_o,
  output logic      deep_entry_o,
  output logic      wake_start_o
);
  sb_state_e st_q, st_d;

  always_comb begin
    st_d         = st_q;
    deep_entry_o = 1'b0;
    wake_start_o = 1'b0;
    if (low_volt_i) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (!irq_i) begin
            if (deep_req_i) begin
              st_d         = ST_DEEP;
              deep_entry_o = 1'b1;
            end else if (light_req_i) begin
              st_d = ST_LIGHT;
            end
          end
        end
        ST_LIGHT: if (irq_i) st_d = ST_RUN;
        ST_DEEP: begin
          if (irq_i) begin
            st_d         = ST_WAKE;
            wake_start_o = 1'b1;
          end
        end
        ST_WAKE: if (tmr_done_i) st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
  parameter int SEL_W    = 4,
  parameter int BASE_EXP = 8,
  localparam int CNT_W   = (1 << SEL_W) - 1 + BASE_EXP + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic             done_o
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // wait of 2^(sel+BASE_EXP) cycles: load that value minus one, count to zero
  assign load_val = (CNT_W'(1) << (int'(sel_q) + BASE_EXP)) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= '0;
    else if (capture_i) sel_q <= sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (start_i)              cnt_q <= load_val;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/standby_out.sv
module standby_out
  import standby_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sb_state_e state_i,
  input  logic      deep_entry_i,
  input  logic      low_volt_i,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      osc_en_o,
  output logic      part_rst_o,
  output logic      rst_req_o
);
  logic part_rst_q, rst_req_q;

  always_comb begin
    unique case (state_i)
      ST_RUN:   {osc_en_o, per_clk_en_o, cpu_clk_en_o} = 3'b111;
      ST_LIGHT: {osc_en_o, per_clk_en_o, cpu_clk_en_o} = 3'b110;
      ST_DEEP:  {osc_en_o, per_clk_en_o, cpu_clk_en_o} = 3'b000;
      ST_WAKE:  {osc_en_o, per_clk_en_o, cpu_clk_en_o} = 3'b100;
      default:  {osc_en_o, per_clk_en_o, cpu_clk_en_o} = 3'b111;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_rst_q <= 1'b0;
      rst_req_q  <= 1'b0;
    end else begin
      part_rst_q <= deep_entry_i;
      rst_req_q  <= low_volt_i;
    end
  end

  assign part_rst_o = part_rst_q;
  assign rst_req_o  = rst_req_q;
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int BASE_EXP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             light_req_i,
  input  logic             deep_req_i,
  input  logic             irq_i,
  input  logic             low_volt_i,
  input  logic [SEL_W-1:0] stab_sel_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             part_rst_o,
  output logic             rst_req_o,
  output logic [1:0]       state_o
);
  sb_state_e st;
  logic      deep_entry, wake_start, tmr_done;

  standby_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .light_req_i (light_req_i),
    .deep_req_i  (deep_req_i),
    .irq_i       (irq_i),
    .low_volt_i  (low_volt_i),
    .tmr_done_i  (tmr_done),
    .state_o     (st),
    .deep_entry_o(deep_entry),
    .wake_start_o(wake_start)
  );

  stab_timer #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(deep_entry),
    .sel_i    (stab_sel_i),
    .start_i  (wake_start),
    .run_i    (st == ST_WAKE),
    .clear_i  (low_volt_i),
    .done_o   (tmr_done)
  );

  standby_out i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (st),
    .deep_entry_i(deep_entry),
    .low_volt_i  (low_volt_i),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o),
    .osc_en_o    (osc_en_o),
    .part_rst_o  (part_rst_o),
    .rst_req_o   (rst_req_o)
  );

  assign state_o = st;
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       light_req_i,
  input logic       deep_req_i,
  input logic       irq_i,
  input logic       low_volt_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       osc_en_o,
  input logic       part_rst_o,
  input logic       rst_req_o,
  input logic [1:0] state_o
);
  AST_LIGHT_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b01 |-> !cpu_clk_en_o && per_clk_en_o && osc_en_o); // R2
  AST_DEEP_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 |-> !cpu_clk_en_o && !per_clk_en_o && !osc_en_o); // R3
  AST_PART_RST_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_o |-> state_o == 2'b10 && $past(state_o) == 2'b00); // R4
  AST_LIGHT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b01 && irq_i && !low_volt_i |=> state_o == 2'b00 && cpu_clk_en_o); // R5
  AST_WAKE_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b11 |-> osc_en_o && !cpu_clk_en_o && !per_clk_en_o); // R6
  AST_WAKE_FROM_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o == 2'b11) |-> $past(state_o) == 2'b10); // R7
  AST_IRQ_BLOCKS_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b00 && irq_i |=> state_o == 2'b00); // R8
  AST_DEEP_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b00 && light_req_i && deep_req_i && !irq_i && !low_volt_i
    |=> state_o == 2'b10); // R9
  AST_LOW_VOLT_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_volt_i |=> rst_req_o && state_o == 2'b00 && osc_en_o && cpu_clk_en_o); // R10
endmodule

bind standby_ctrl standby_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .light_req_i (light_req_i),
  .deep_req_i  (deep_req_i),
  .irq_i       (irq_i),
  .low_volt_i  (low_volt_i),
  .cpu_clk_en_o(cpu_clk_en_o),
  .per_clk_en_o(per_clk_en_o),
  .osc_en_o    (osc_en_o),
  .part_rst_o  (part_rst_o),
  .rst_req_o   (rst_req_o),
  .state_o     (state_o)
);

// File: tb/test_standby_ctrl.sv
`timescale 1ns/1ps
module test_standby_ctrl;
  localparam int SEL_W = 4;
  localparam int BASE  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic light = 0, deep = 0, irq = 0, lv = 0;
  logic [SEL_W-1:0] sel = '0;
  logic cpu_en, per_en, osc_en, prst, rreq;
  logic [1:0] st;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  standby_ctrl #(.SEL_W(SEL_W), .BASE_EXP(BASE)) i_standby_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .light_req_i(light), .deep_req_i(deep),
    .irq_i(irq), .low_volt_i(lv), .stab_sel_i(sel),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .part_rst_o(prst), .rst_req_o(rreq), .state_o(st)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {state, osc, per, cpu}
  function automatic logic [7:0] snap();
    return {3'b0, st, osc_en, per_en, cpu_en};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic go_deep(logic [SEL_W-1:0] s);
    sel = s; deep = 1; step(); deep = 0;
  endtask

  task automatic t_reset();
    chk("R1 state/enables", snap(), 8'b000_00_111);
    chk("R1 pulses", {6'b0, prst, rreq}, 8'h00);
  endtask

  task automatic t_light();
    light = 1; step(); light = 0;
    chk("R2 light enables", snap(), 8'b000_01_110);
    chk("R4 no pulse on light", {7'b0, prst}, 8'h00);
    step();
    chk("R2 light held", snap(), 8'b000_01_110);
    irq = 1; step(); irq = 0;
    chk("R5 immediate exit", snap(), 8'b000_00_111);
  endtask

  task automatic t_deep_wait(logic [SEL_W-1:0] s0, logic [SEL_W-1:0] s1, bit noise);
    int n = 0;
    go_deep(s0);
    chk("R3 deep enables", snap(), 8'b000_10_000);
    chk("R4 pulse high", {7'b0, prst}, 8'h01);
    sel = s1; step();
    chk("R4 pulse one cycle", {7'b0, prst}, 8'h00);
    chk("R3 deep held", snap(), 8'b000_10_000);
    irq = 1; step(); irq = 0;
    chk("R6 waking enables", snap(), 8'b000_11_100);
    while (st == 2'b11 && n < 100000) begin
      n++;
      if (noise) irq = n[0];
      step();
    end
    irq = 0;
    chk("R7 wait length", 8'(n), 8'(1 << (int'(s0) + BASE)));
    chk("R7 run after wait", snap(), 8'b000_00_111);
  endtask

  task automatic t_irq_block();
    irq = 1; light = 1; step();
    chk("R8 light ignored", {6'b0, st}, 8'h00);
    light = 0; deep = 1; step(); deep = 0; irq = 0;
    chk("R8 deep ignored", {6'b0, st}, 8'h00);
    chk("R8 no pulse", {7'b0, prst}, 8'h00);
  endtask

  task automatic t_both();
    light = 1; deep = 1; step(); light = 0; deep = 0;
    chk("R9 deep wins", snap(), 8'b000_10_000);
    irq = 1; step(); irq = 0;
    while (st == 2'b11) step();
  endtask

  task automatic t_low_volt();
    go_deep(4'd0);
    lv = 1; step();
    chk("R10 request", {7'b0, rreq}, 8'h01);
    chk("R10 forced run", snap(), 8'b000_00_111);
    deep = 1; light = 1; step(); deep = 0; light = 0;
    chk("R10 strobes ignored", snap(), 8'b000_00_111);
    lv = 0; step();
    chk("R10 request drops", {7'b0, rreq}, 8'h00);
    chk("R10 stays run", {6'b0, st}, 8'h00);
    light = 1; step(); light = 0; lv = 1; step(); lv = 0;
    chk("R10 from light", {5'b0, rreq, st}, 8'h04);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_light();
    t_deep_wait(4'd0, 4'd0, 0);
    t_deep_wait(4'd1, 4'd1, 1);
    t_deep_wait(4'd0, 4'd3, 0);
    t_deep_wait(4'd3, 4'd0, 1);
    t_irq_block();
    t_both();
    t_low_volt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule